// File: doc/BRIEF.md
# Binary32 Multiplier with Selectable Rounding

This block multiplies two IEEE 754 binary32 operands and returns the binary32 product together with four exception flags for that product. The caller chooses, with each operand pair, one of four rounding directions. Two further per-operation switches are also sampled with the operands. One flushes subnormal values to zero, on input and on output. The other replaces every NaN result with a single canonical quiet NaN.

The datapath is a two-stage pipeline with no stalls. The first stage decodes both operands and settles every special case: zeros, infinities, NaNs, and the invalid zero-times-infinity combination. It also forms the full 48-bit significand product and a provisional exponent. The second stage normalizes the product, denormalizes it when the exponent is too small, and rounds using guard, round and sticky bits. A single exponent-plus-significand addition then packs the result, so rounding carries move into the exponent field without extra logic. A new operation can start on every clock, and each result appears a fixed two clocks after its operands.

Top module: `fmul32_top`

## Requirements
- R1: `out_valid` equals `in_valid` delayed by exactly two rising clock edges, and a new operation is accepted on every cycle. While `rst_n` is low, `out_valid`, `result` and all four flags are 0.
- R2: With `rnd_mode` = 2'b00, a finite nonzero product is rounded to the nearest representable value. An exact midpoint goes to the value whose least significant fraction bit is 0.
- R3: `rnd_mode` = 2'b01 rounds toward +infinity, 2'b10 rounds toward -infinity, and 2'b11 rounds toward zero.
- R4: `flag_inexact` is 1 exactly when the delivered finite result differs from the exact product, or when overflow occurred. It is 0 for every NaN, infinity, exact-zero or flushed result.
- R5: When the rounded biased exponent reaches 255, `flag_overflow` and `flag_inexact` are both 1. The result is then infinity or the largest finite magnitude (exponent field 254, fraction all ones), with the product's sign. Mode 2'b00 gives infinity and mode 2'b11 gives the largest finite value. Mode 2'b01 gives infinity for a positive product and the largest finite value for a negative one. Mode 2'b10 does the reverse.
- R6: With `ftz_en` = 0, a subnormal operand (exponent field 0) has the value fraction × 2^-149, and tiny products are delivered as subnormals. `flag_underflow` is 1 when the rounded result of a nonzero finite product has exponent field 0, including a product that rounds to zero.
- R7: With `ftz_en` = 1, a subnormal operand acts as a zero of its own sign. A result that would have exponent field 0 is replaced by a zero with the product's sign, with `flag_underflow` = 1 and `flag_inexact` = 0.
- R8: Zero times infinity, in either order, gives 0x7FC00000 with `flag_invalid` = 1, whatever the value of `dnan_en`.
- R9: With `dnan_en` = 0 and a NaN operand (exponent field 255, fraction nonzero), the result is `op_a` if `op_a` is a NaN, otherwise `op_b`, with fraction bit 22 forced to 1. `flag_invalid` is 1 exactly when a NaN operand has bit 22 clear (signaling).
- R10: With `dnan_en` = 1, any NaN operand gives 0x7FC00000, and `flag_invalid` is set as in R9.
- R11: Infinity times a nonzero non-NaN value gives infinity, and zero times a finite value gives zero. In both cases the sign is the XOR of the operand signs and every flag is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operands and controls are presented this cycle |
| op_a | input | 32 | First binary32 operand |
| op_b | input | 32 | Second binary32 operand |
| rnd_mode | input | 2 | Rounding direction: 00 nearest-even, 01 up, 10 down, 11 toward zero |
| ftz_en | input | 1 | Flush subnormal operands and results to zero |
| dnan_en | input | 1 | Return the canonical quiet NaN for every NaN result |
| out_valid | output | 1 | Result and flags are valid this cycle |
| result | output | 32 | Binary32 product |
| flag_invalid | output | 1 | Invalid operation for this result |
| flag_overflow | output | 1 | Overflow for this result |
| flag_underflow | output | 1 | Underflow or flush for this result |
| flag_inexact | output | 1 | Rounding changed the value of this result |

## Verification
Each result depends only on the operands presented two cycles earlier, so any wrong internal value shows up at the ports on the next `out_valid` cycle. A wrong leading-zero count or exponent offset shifts the result by a power of two. A wrong sticky or guard bit shows up as a one-ulp error or a wrong inexact flag on midpoint cases. A wrong denormalization shift breaks every subnormal or underflowing product. A special-case flag captured in stage one but paired with the wrong pipeline slot puts a NaN or infinity on a neighbouring result, and a bench that issues operations back to back with bubbles between them exposes that at once.

// File: rtl/fmul32_pkg.sv
package fmul32_pkg;
  localparam int EXP_W   = 8;
  localparam int FRAC_W  = 23;
  localparam int WORD_W  = 1 + EXP_W + FRAC_W;
  localparam int SIG_W   = FRAC_W + 1;
  localparam int PROD_W  = 2 * SIG_W;
  localparam int BIAS    = (1 << (EXP_W - 1)) - 1;
  localparam int EXP_ALL = (1 << EXP_W) - 1;
  localparam int EXT_W   = EXP_W + 3;
  localparam int LZ_W    = $clog2(PROD_W + 1);
  localparam int SUM_W   = EXT_W + FRAC_W;

  localparam logic [WORD_W-1:0] QNAN_CANON =
    {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};

  typedef enum logic [1:0] {
    RM_NEAREST = 2'b00,
    RM_UP      = 2'b01,
    RM_DOWN    = 2'b10,
    RM_ZERO    = 2'b11
  } rmode_e;

  typedef struct packed {
    logic [EXP_W-1:0] eexp;
    logic [SIG_W-1:0] sig;
    logic             zero;
    logic             inf;
    logic             nan;
    logic             snan;
  } opnd_t;

  // Position of the highest set bit, expressed as a count of leading zeros.
  function automatic logic [LZ_W-1:0] lead_zeros(input logic [PROD_W-1:0] v);
    lead_zeros = LZ_W'(PROD_W);
    for (int i = 0; i < PROD_W; i++)
      if (v[i]) lead_zeros = LZ_W'(PROD_W - 1 - i);
  endfunction

  // Whether the kept significand must be bumped by one unit.
  function automatic logic round_bump(input rmode_e rm, input logic sign,
                                      input logic lsb, input logic g,
                                      input logic r, input logic s);
    case (rm)
      RM_NEAREST: round_bump = g & (r | s | lsb);
      RM_UP:      round_bump = (g | r | s) & ~sign;
      RM_DOWN:    round_bump = (g | r | s) & sign;
      default:    round_bump = 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/fmul32_classify.sv
module fmul32_classify
  import fmul32_pkg::*;
(
  input  logic [WORD_W-1:0] word,
  input  logic              ftz,
  output opnd_t             info
);
  logic [EXP_W-1:0]  ex;
  logic [FRAC_W-1:0] fr;
  logic              ex_zero, ex_ones, fr_any;

  always_comb begin
    ex      = word[WORD_W-2 -: EXP_W];
    fr      = word[FRAC_W-1:0];
    ex_zero = (ex == '0);
    ex_ones = (ex == '1);
    fr_any  = |fr;
    info.nan  = ex_ones & fr_any;
    info.snan = ex_ones & fr_any & ~fr[FRAC_W-1];
    info.inf  = ex_ones & ~fr_any;
    info.zero = ex_zero & (~fr_any | ftz);
    info.sig  = {~ex_zero, fr};
    info.eexp = ex_zero ? EXP_W'(1) : ex;
  end
endmodule

// File: rtl/fmul32_special.sv
module fmul32_special
  import fmul32_pkg::*;
(
  input  opnd_t             a,
  input  opnd_t             b,
  input  logic [WORD_W-1:0] word_a,
  input  logic [WORD_W-1:0] word_b,
  input  logic              sign,
  input  logic              dnan,
  output logic              is_special,
  output logic              invalid,
  output logic [WORD_W-1:0] spec_res
);
  logic             any_nan, zero_inf;
  logic [WORD_W-1:0] quieted;

  always_comb begin
    any_nan    = a.nan | b.nan;
    zero_inf   = (a.zero & b.inf) | (a.inf & b.zero);
    is_special = any_nan | a.inf | b.inf | a.zero | b.zero;
    invalid    = any_nan ? (a.snan | b.snan) : zero_inf;
    quieted    = (a.nan ? word_a : word_b) | (WORD_W'(1) << (FRAC_W - 1));
    if (any_nan)
      spec_res = dnan ? QNAN_CANON : quieted;
    else if (zero_inf)
      spec_res = QNAN_CANON;
    else if (a.inf | b.inf)
      spec_res = {sign, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
    else
      spec_res = {sign, {(WORD_W-1){1'b0}}};
  end
endmodule

// File: rtl/fmul32_round.sv
module fmul32_round
  import fmul32_pkg::*;
(
  input  logic                    sign,
  input  logic signed [EXT_W-1:0] bexp,
  input  logic [PROD_W-1:0]       prod,
  input  rmode_e                  rm,
  input  logic                    ftz,
  output logic [WORD_W-1:0]       res,
  output logic                    ovf,
  output logic                    uf,
  output logic                    inx
);
  logic [LZ_W-1:0]         lz;
  logic [PROD_W-1:0]       norm, den, mask;
  logic signed [EXT_W-1:0] be_n, sh;
  logic [LZ_W-1:0]         sh_c;
  logic                    tiny, lost;
  logic [SIG_W-1:0]        keep;
  logic                    g_bit, r_bit, s_bit, bump, rnd_loss, to_inf;
  logic [EXT_W-1:0]        exp_adj, fe;
  logic [SUM_W-1:0]        packed_sum;

  always_comb begin
    lz    = lead_zeros(prod);
    norm  = prod << lz;
    be_n  = bexp - $signed({{(EXT_W-LZ_W){1'b0}}, lz});
    tiny  = (be_n < $signed(EXT_W'(1)));
    sh    = EXT_W'(1) - be_n;
    sh_c  = (sh > $signed(EXT_W'(PROD_W))) ? LZ_W'(PROD_W) : sh[LZ_W-1:0];
    mask  = (PROD_W'(1) << sh_c) - PROD_W'(1);
    den   = tiny ? (norm >> sh_c) : norm;
    lost  = tiny & |(norm & mask);
    // guard, round and sticky sit just below the kept significand
    keep  = den[PROD_W-1 -: SIG_W];
    g_bit = den[PROD_W-SIG_W-1];
    r_bit = den[PROD_W-SIG_W-2];
    s_bit = |den[PROD_W-SIG_W-3:0] | lost;
    rnd_loss = g_bit | r_bit | s_bit;
    bump  = round_bump(rm, sign, keep[0], g_bit, r_bit, s_bit);
    // hidden bit of keep adds one to the field, so the normal path stores be_n-1
    exp_adj = tiny ? '0 : ($unsigned(be_n) - EXT_W'(1));
    packed_sum = {exp_adj, {FRAC_W{1'b0}}} + SUM_W'(keep) + SUM_W'(bump);
    fe    = packed_sum[SUM_W-1:FRAC_W];
    ovf   = (fe >= EXT_W'(EXP_ALL));
    uf    = (fe == '0);
    to_inf = (rm == RM_NEAREST) | ((rm == RM_UP) & ~sign) | ((rm == RM_DOWN) & sign);
    inx   = rnd_loss | ovf;
    if (ovf)
      res = to_inf ? {sign, {EXP_W{1'b1}}, {FRAC_W{1'b0}}}
                   : {sign, {(EXP_W-1){1'b1}}, 1'b0, {FRAC_W{1'b1}}};
    else if (uf && ftz) begin
      res = {sign, {(WORD_W-1){1'b0}}};
      inx = 1'b0;
    end else
      res = {sign, fe[EXP_W-1:0], packed_sum[FRAC_W-1:0]};
  end
endmodule

// File: rtl/fmul32_top.sv
module fmul32_top
  import fmul32_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  input  logic [31:0] op_a,
  input  logic [31:0] op_b,
  input  logic [1:0]  rnd_mode,
  input  logic        ftz_en,
  input  logic        dnan_en,
  output logic        out_valid,
  output logic [31:0] result,
  output logic        flag_invalid,
  output logic        flag_overflow,
  output logic        flag_underflow,
  output logic        flag_inexact
);
  // ---------------- stage 1: decode, special cases, raw product
  opnd_t                   ua, ub;
  logic                    sign_c, spec_c, inv_c;
  logic [WORD_W-1:0]       spec_res_c;
  logic signed [EXT_W-1:0] bexp_c;
  logic [PROD_W-1:0]       prod_c;

  fmul32_classify cls_a (.word(op_a), .ftz(ftz_en), .info(ua));
  fmul32_classify cls_b (.word(op_b), .ftz(ftz_en), .info(ub));

  assign sign_c = op_a[WORD_W-1] ^ op_b[WORD_W-1];
  assign bexp_c = $signed(EXT_W'(ua.eexp)) + $signed(EXT_W'(ub.eexp))
                - $signed(EXT_W'(BIAS - 1));
  assign prod_c = PROD_W'(ua.sig) * PROD_W'(ub.sig);

  fmul32_special spc (
    .a(ua), .b(ub), .word_a(op_a), .word_b(op_b), .sign(sign_c),
    .dnan(dnan_en), .is_special(spec_c), .invalid(inv_c), .spec_res(spec_res_c)
  );

  logic                    v1, sign1, spec1, inv1, ftz1;
  logic [WORD_W-1:0]       spec_res1;
  logic signed [EXT_W-1:0] bexp1;
  logic [PROD_W-1:0]       prod1;
  rmode_e                  rm1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v1 <= 1'b0; sign1 <= 1'b0; spec1 <= 1'b0; inv1 <= 1'b0; ftz1 <= 1'b0;
      spec_res1 <= '0; bexp1 <= '0; prod1 <= '0; rm1 <= RM_NEAREST;
    end else begin
      v1 <= in_valid;
      if (in_valid) begin
        sign1 <= sign_c; spec1 <= spec_c; inv1 <= inv_c; ftz1 <= ftz_en;
        spec_res1 <= spec_res_c; bexp1 <= bexp_c; prod1 <= prod_c;
        rm1 <= rmode_e'(rnd_mode);
      end
    end
  end

  // ---------------- stage 2: normalize, round, pack
  logic [WORD_W-1:0] rnd_res_w;
  logic              rnd_ovf_w, rnd_uf_w, rnd_inx_w;

  fmul32_round rnd (
    .sign(sign1), .bexp(bexp1), .prod(prod1), .rm(rm1), .ftz(ftz1),
    .res(rnd_res_w), .ovf(rnd_ovf_w), .uf(rnd_uf_w), .inx(rnd_inx_w)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0; result <= '0;
      flag_invalid <= 1'b0; flag_overflow <= 1'b0;
      flag_underflow <= 1'b0; flag_inexact <= 1'b0;
    end else begin
      out_valid <= v1;
      if (v1) begin
        result         <= spec1 ? spec_res1 : rnd_res_w;
        flag_invalid   <= spec1 & inv1;
        flag_overflow  <= ~spec1 & rnd_ovf_w;
        flag_underflow <= ~spec1 & rnd_uf_w;
        flag_inexact   <= ~spec1 & rnd_inx_w;
      end
    end
  end

  // ---------------- assertions
  logic [1:0] since_rst;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) since_rst <= '0;
    else if (since_rst != 2'd2) since_rst <= since_rst + 2'd1;
  end

  logic out_is_nan_w;
  assign out_is_nan_w = (result[30:23] == 8'hFF) && (result[22:0] != '0);

  p_valid_lat_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst == 2'd2) |-> (out_valid == $past(in_valid, 2)));

  p_ovf_sat_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && flag_overflow) |->
      (flag_inexact && (result[30:0] == 31'h7F800000 || result[30:0] == 31'h7F7FFFFF)));

  p_uf_field_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && flag_underflow) |-> (result[30:23] == 8'h00 && !flag_overflow));

  p_ftz_nosub_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst == 2'd2 && out_valid && $past(ftz_en, 2) && result[30:23] == 8'h00)
      |-> (result[22:0] == '0 && !flag_inexact));

  p_inv_clean_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && flag_invalid) |->
      (out_is_nan_w && !flag_overflow && !flag_underflow && !flag_inexact));

  p_nan_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_is_nan_w) |-> result[22]);

  p_dnan_canon_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst == 2'd2 && out_valid && $past(dnan_en, 2) && out_is_nan_w)
      |-> (result == QNAN_CANON));
endmodule

// File: tb/fmul32_top_tb_top.sv
module fmul32_top_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [31:0] op_a = '0, op_b = '0;
  logic [1:0]  rnd_mode = '0;
  logic        ftz_en = 1'b0, dnan_en = 1'b0;
  logic        out_valid;
  logic [31:0] result;
  logic        flag_invalid, flag_overflow, flag_underflow, flag_inexact;

  always #4 clk = ~clk;  // 125 MHz

  fmul32_top dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
    .rnd_mode(rnd_mode), .ftz_en(ftz_en), .dnan_en(dnan_en),
    .out_valid(out_valid), .result(result), .flag_invalid(flag_invalid),
    .flag_overflow(flag_overflow), .flag_underflow(flag_underflow),
    .flag_inexact(flag_inexact)
  );

  int total = 0;
  int bad = 0;
  bit done = 0;

  function automatic real pow2(input int n);
    real r = 1.0;
    if (n >= 0) for (int i = 0; i < n; i++) r = r * 2.0;
    else        for (int i = 0; i < -n; i++) r = r * 0.5;
    return r;
  endfunction

  function automatic real magnitude(input logic [31:0] w);
    int e = int'(w[30:23]);
    if (e == 0) return real'(w[22:0]) * pow2(-149);
    return real'({1'b1, w[22:0]}) * pow2(e - 150);
  endfunction

  // Reference product from exact double-precision arithmetic.
  function automatic void ref_mul(input logic [31:0] a, input logic [31:0] b,
                                  input logic [1:0] rm, input logic ftz, input logic dn,
                                  output logic [31:0] res, output logic inv,
                                  output logic ovf, output logic uf, output logic inx,
                                  output string tag);
    logic s, na, nb, sa, sb, ia, ib, za, zb;
    real p;
    logic [63:0] bits;
    longint unsigned sig, keep, rem, half;
    int ue, qe, shft, fld;
    logic up, exact;
    s  = a[31] ^ b[31];
    na = (a[30:23] == 8'hFF) && (a[22:0] != 0);
    nb = (b[30:23] == 8'hFF) && (b[22:0] != 0);
    sa = na && !a[22];
    sb = nb && !b[22];
    ia = (a[30:23] == 8'hFF) && (a[22:0] == 0);
    ib = (b[30:23] == 8'hFF) && (b[22:0] == 0);
    za = (a[30:23] == 0) && ((a[22:0] == 0) || ftz);
    zb = (b[30:23] == 0) && ((b[22:0] == 0) || ftz);
    inv = 0; ovf = 0; uf = 0; inx = 0;
    if (na || nb) begin
      inv = sa || sb;
      res = dn ? 32'h7FC00000 : ((na ? a : b) | 32'h00400000);
      tag = dn ? "R10" : "R9";
      return;
    end
    if ((ia && zb) || (za && ib)) begin
      inv = 1; res = 32'h7FC00000; tag = "R8"; return;
    end
    if (ia || ib) begin res = {s, 8'hFF, 23'd0}; tag = "R11"; return; end
    if (za || zb) begin
      res = {s, 31'd0};
      tag = (ftz && (a[30:23] == 0 || b[30:23] == 0)) ? "R7" : "R11";
      return;
    end
    p    = magnitude(a) * magnitude(b);
    bits = $realtobits(p);
    sig  = {11'd0, 1'b1, bits[51:0]};
    ue   = int'(bits[62:52]) - 1023;
    qe   = ((ue < -126) ? -126 : ue) - 23;
    shft = qe - (ue - 52);
    if (shft >= 62) begin
      keep = 0; exact = 0; up = (rm == 2'b01) ? !s : (rm == 2'b10) ? s : 1'b0;
    end else begin
      keep  = sig >> shft;
      rem   = sig & ((64'd1 << shft) - 64'd1);
      half  = 64'd1 << (shft - 1);
      exact = (rem == 0);
      case (rm)
        2'b00:   up = (rem > half) || (rem == half && keep[0]);
        2'b01:   up = !exact && !s;
        2'b10:   up = !exact && s;
        default: up = 0;
      endcase
    end
    inx  = !exact;
    keep = keep + (up ? 64'd1 : 64'd0);
    if (keep == 64'd1 << 24) begin keep = 64'd1 << 23; qe = qe + 1; end
    fld = (keep >= (64'd1 << 23)) ? qe + 150 : 0;
    if (fld >= 255) begin
      ovf = 1; inx = 1; tag = "R5";
      if (rm == 2'b00 || (rm == 2'b01 && !s) || (rm == 2'b10 && s))
        res = {s, 8'hFF, 23'd0};
      else
        res = {s, 8'hFE, 23'h7FFFFF};
      return;
    end
    if (fld == 0) begin
      uf = 1;
      if (ftz) begin res = {s, 31'd0}; inx = 0; tag = "R7"; return; end
      res = {s, 8'd0, keep[22:0]}; tag = "R6"; return;
    end
    res = {s, fld[7:0], keep[22:0]};
    tag = (rm == 2'b00) ? "R2" : "R3";
  endfunction

  // Two-slot model of the pipeline: slot 1 issued one step ago, slot 2 two steps ago.
  logic        ev1 = 0, ev2 = 0;
  logic [35:0] e1 = '0, e2 = '0;
  logic [31:0] a1 = '0, b1 = '0, a2 = '0, b2 = '0;
  string       t1 = "R1", t2 = "R1";

  task automatic step(input logic v, input logic [31:0] a, input logic [31:0] b,
                      input logic [1:0] rm, input logic f, input logic d);
    logic [31:0] r;
    logic i, o, u, x;
    string t;
    @(negedge clk);
    total++;
    if (out_valid !== ev2) begin
      bad++;
      $display("FAIL R1 out_valid got=%b expected=%b", out_valid, ev2);
    end
    if (ev2) begin
      total++;
      if ({result, flag_invalid, flag_overflow, flag_underflow} !== e2[35:1]) begin
        bad++;
        $display("FAIL %s a=%h b=%h got=%h inv/ovf/uf=%b%b%b expected=%h inv/ovf/uf=%b",
                 t2, a2, b2, result, flag_invalid, flag_overflow, flag_underflow,
                 e2[35:4], e2[3:1]);
      end
      total++;
      if (flag_inexact !== e2[0]) begin
        bad++;
        $display("FAIL R4 a=%h b=%h inexact got=%b expected=%b", a2, b2, flag_inexact, e2[0]);
      end
    end
    ev2 = ev1; e2 = e1; t2 = t1; a2 = a1; b2 = b1;
    if (v) ref_mul(a, b, rm, f, d, r, i, o, u, x, t);
    else begin r = '0; i = 0; o = 0; u = 0; x = 0; t = "R1"; end
    ev1 = v; e1 = {r, i, o, u, x}; t1 = t; a1 = a; b1 = b;
    in_valid = v; op_a = a; op_b = b; rnd_mode = rm; ftz_en = f; dnan_en = d;
  endtask

  logic [31:0] ops [0:23];

  initial begin
    ops = '{32'h00000000, 32'h80000000, 32'h3F800000, 32'hBF800000,
            32'h3FC00000, 32'h3F800001, 32'h3FFFFFFF, 32'h7F7FFFFF,
            32'hFF7FFFFF, 32'h00800000, 32'h00000001, 32'h807FFFFF,
            32'h00400000, 32'h7F800000, 32'hFF800000, 32'h7FC00001,
            32'h7F800005, 32'hFFA00000, 32'h34000000, 32'h4B000001,
            32'h4B000003, 32'h5F000000, 32'h1FFFFFFF, 32'h3F000001};
    repeat (3) @(negedge clk);
    // R1: reset values
    total++;
    if ({out_valid, result, flag_invalid, flag_overflow, flag_underflow, flag_inexact} !== '0) begin
      bad++;
      $display("FAIL R1 reset outputs got=%b/%h expected=0/00000000", out_valid, result);
    end
    rst_n = 1'b1;
    for (int i = 0; i < 24; i++)
      for (int j = 0; j < 24; j++)
        for (int m = 0; m < 16; m++) begin
          if (((i * 24 + j) * 16 + m) % 13 == 0) step(0, '0, '0, 2'b00, 0, 0);
          step(1, ops[i], ops[j], m[1:0], m[2], m[3]);
        end
    for (int k = 0; k < 6000; k++) begin
      logic [31:0] ra, rb;
      logic [3:0]  ctl;
      ra  = $urandom;
      rb  = $urandom;
      ctl = 4'($urandom);
      if (k % 3 == 1) begin
        ra[30:23] = 8'(100 + $urandom % 55);
        rb[30:23] = 8'(100 + $urandom % 55);
      end else if (k % 3 == 2) begin
        ra[30:23] = 8'($urandom % 31);
        rb[30:23] = 8'(60 + $urandom % 67);
      end
      step(1, ra, rb, ctl[1:0], ctl[2], ctl[3]);
    end
    step(0, '0, '0, 2'b00, 0, 0);
    step(0, '0, '0, 2'b00, 0, 0);
    step(0, '0, '0, 2'b00, 0, 0);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired before the run completed");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule